// File: doc/BRIEF.md
# Dual-Host Secondary Interrupt Controller

This block gathers a bank of asynchronous interrupt sources and presents them to two independent host-side interrupt lines. Every source passes through a synchronizer and an edge detector whose trigger selection (rising, falling, both or none) is one shared configuration for both lines. Each line keeps its own status bits and its own mask bits. A detected edge on an unmasked source sets that line's status bit, and the line's active-low output is low while any of its status bits is set.

Software works through a byte-wide register port. One control register selects how status bits are cleared: by reading them, or by writing 1s to them. The same register selects what happens when a source fires again before its earlier event has been cleared: the second event is either held over or dropped. Status and mask are multi-byte little-endian fields with ceil(N_SRC/8) bytes each. Byte addresses: status of line L, byte b at 4L+b. Mask of line L, byte b at 8+4L+b. Edge byte k at 16+k. Control at 24. Unmapped addresses read as zero.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Each line has private status and mask registers; an event sets status only on lines whose mask bit for that source is 0, while the edge configuration is common to both lines.
- R2: Source i is configured by edge byte i/4 at bit offset (i mod 4)*2. The higher bit of the pair enables rising detection and the lower bit enables falling detection. A source change presented before a clock edge sets status at the third rising edge.
- R3: A source whose two edge bits are both 0 never sets a status bit on either line.
- R4: After reset all mask bits are 1, all status, edge and control bits are 0, and both interrupt outputs are high.
- R5: With control bit 0 (clear-on-read) at 1, a read of a status byte returns its bits and clears exactly those bits; the data appears on rdata_o one cycle after the read strobe.
- R6: With control bit 0 at 0, writing a 1 to a status bit clears it. With control bit 0 at 1, writes to status bytes have no effect.
- R7: With control bit 1 (drop-repeat) at 0, an event on a source whose status bit is already set is held over, so the bit is still set after the first clear and needs a second clear.
- R8: With control bit 1 at 1, an event on a source whose status bit is already set is discarded, so one clear leaves the bit at 0.
- R9: Status and mask bytes are little-endian: byte b holds sources 8b to 8b+7, with source 8b in bit 0.
- R10: A line's interrupt output is the registered NOR of its status bits: it goes low one cycle after a status bit is set and returns high one cycle after the last one is cleared.
- R11: When an event and a clear hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Asynchronous interrupt sources |
| addr_i | input | AW | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| irq_no | output | 2 | Active-low interrupt per line |

## Verification
A status bit can be cleared and set by a new edge in the same cycle. That can happen under both clear modes and under both repeat policies. The bench sets a status bit, turns on drop-repeat, and schedules a clear-on-read strobe so that it meets the cycle in which the synchronized edge of the same source is detected. The bit is judged by the data of that read, which must show the bit, and by the two reads after it: the first must show the bit still set and the second must show it cleared. The hold-over path is also crossed with both clear styles, so that repeat events meet both write-clear and read-clear passes.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;
  localparam int unsigned LINES  = 2;
  localparam int unsigned A_STAT = 0;
  localparam int unsigned A_MASK = 8;
  localparam int unsigned A_EDGE = 16;
  localparam int unsigned A_CTRL = 24;
  localparam int unsigned LINE_STRIDE = 4;

  typedef struct packed {
    logic pend_dis;
    logic cor;
  } ctrl_t;
endpackage

// File: rtl/sec_irq_edge.sv
module sec_irq_edge #(
  parameter int unsigned N = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   src_i,
  input  logic [2*N-1:0] cfg_i,
  output logic [N-1:0]   ev_o
);
  logic [N-1:0] s1_q, s2_q, prv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      prv_q <= '0;
    end else begin
      s1_q  <= src_i;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  // pair per source: [2i+1] rising, [2i] falling
  for (genvar i = 0; i < N; i++) begin : g_det
    assign ev_o[i] = (s2_q[i] & ~prv_q[i] & cfg_i[2*i+1]) |
                     (~s2_q[i] & prv_q[i] & cfg_i[2*i]);
  end
endmodule

// File: rtl/sec_irq_line.sv
module sec_irq_line #(
  parameter int unsigned N  = 24,
  parameter int unsigned NB = (N + 7) / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  ev_i,
  input  logic [N-1:0]  clr_i,
  input  logic          pend_dis_i,
  input  logic [NB-1:0] mask_we_i,
  input  logic [7:0]    wdata_i,
  output logic [N-1:0]  stat_o,
  output logic [N-1:0]  mask_o,
  output logic          irq_no
);
  logic [NB*8-1:0] mask_q;
  logic [N-1:0]    stat_q, pend_q, hit, stat_d, pend_d;
  logic            irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '1;
    else begin
      for (int b = 0; b < int'(NB); b++)
        if (mask_we_i[b]) mask_q[b*8 +: 8] <= wdata_i;
    end
  end

  assign mask_o = mask_q[N-1:0];
  assign hit    = ev_i & ~mask_o;

  always_comb begin
    // new event wins over clear; held-over event refills a cleared bit
    stat_d = hit | (stat_q & ~clr_i) | (stat_q & clr_i & pend_q);
    if (pend_dis_i) pend_d = '0;
    else            pend_d = (pend_q & ~clr_i) | (stat_q & hit & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b1;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
      irq_q  <= ~|stat_q;
    end
  end

  assign stat_o = stat_q;
  assign irq_no = irq_q;

  // R1
  no_masked_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~$past(stat_q) & $past(mask_o)) == '0);
  // R11
  ev_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & clr_i) != '0) |=> ((stat_q & $past(hit & clr_i)) == $past(hit & clr_i)));
  // R8
  pend_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_dis_i |=> (pend_q == '0));
  // R10
  irq_nor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q != '0) |=> !irq_no);
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
  import sec_irq_pkg::*;
#(
  parameter int unsigned N_SRC = 24,
  parameter int unsigned AW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wdata_i,
  input  logic             rd_en_i,
  output logic [7:0]       rdata_o,
  output logic [1:0]       irq_no
);
  localparam int unsigned NB = (N_SRC + 7) / 8;
  localparam int unsigned NE = (2 * N_SRC + 7) / 8;

  logic [NE*8-1:0]  edge_q;
  ctrl_t            ctrl_q;
  logic [N_SRC-1:0] ev;
  logic [N_SRC-1:0] stat [LINES];
  logic [N_SRC-1:0] mask [LINES];
  logic [7:0]       rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      for (int k = 0; k < int'(NE); k++)
        if (addr_i == AW'(A_EDGE + k)) edge_q[k*8 +: 8] <= wdata_i;
      if (addr_i == AW'(A_CTRL)) ctrl_q <= ctrl_t'(wdata_i[1:0]);
    end
  end

  sec_irq_edge #(.N(N_SRC)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .cfg_i (edge_q[2*N_SRC-1:0]),
    .ev_o  (ev)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [NB*8-1:0] stat_ext, clr_ext;
    logic [NB-1:0]   mask_we;

    always_comb begin
      stat_ext = '0;
      stat_ext[N_SRC-1:0] = stat[l];
      clr_ext = '0;
      for (int b = 0; b < int'(NB); b++) begin
        mask_we[b] = wr_en_i && (addr_i == AW'(A_MASK + l*LINE_STRIDE + b));
        if (addr_i == AW'(A_STAT + l*LINE_STRIDE + b)) begin
          if (rd_en_i && ctrl_q.cor)       clr_ext[b*8 +: 8] = stat_ext[b*8 +: 8];
          else if (wr_en_i && !ctrl_q.cor) clr_ext[b*8 +: 8] = wdata_i;
        end
      end
    end

    sec_irq_line #(.N(N_SRC), .NB(NB)) u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev),
      .clr_i     (clr_ext[N_SRC-1:0]),
      .pend_dis_i(ctrl_q.pend_dis),
      .mask_we_i (mask_we),
      .wdata_i   (wdata_i),
      .stat_o    (stat[l]),
      .mask_o    (mask[l]),
      .irq_no    (irq_no[l])
    );
  end

  always_comb begin
    logic [NB*8-1:0] se, me;
    rd_mux = '0;
    for (int l = 0; l < int'(LINES); l++) begin
      se = '0; se[N_SRC-1:0] = stat[l];
      me = '1; me[N_SRC-1:0] = mask[l];
      for (int b = 0; b < int'(NB); b++) begin
        if (addr_i == AW'(A_STAT + l*LINE_STRIDE + b)) rd_mux = se[b*8 +: 8];
        if (addr_i == AW'(A_MASK + l*LINE_STRIDE + b)) rd_mux = me[b*8 +: 8];
      end
    end
    for (int k = 0; k < int'(NE); k++)
      if (addr_i == AW'(A_EDGE + k)) rd_mux = edge_q[k*8 +: 8];
    if (addr_i == AW'(A_CTRL)) rd_mux = {6'b0, ctrl_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // R3
  dead_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev & ~{N_SRC{1'b0}}) & ~(edge_q[2*N_SRC-1:0] != '0 ? '1 : '0)) == '0);
  // R6
  cor_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_q.cor && addr_i == AW'(A_STAT)) |=>
      ((~stat[0][7:0] & $past(stat[0][7:0])) == 8'h00));
endmodule

// File: tb/sec_irq_ctrl_tb_top.sv
module sec_irq_ctrl_tb_top;
  localparam int N = 24;
  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  src = '0;
  logic [4:0]    addr = '0;
  logic          wr_en = 0, rd_en = 0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [1:0]    irq_n;
  int total = 0, bad = 0;
  logic rd_q = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  sec_irq_ctrl #(.N_SRC(N), .AW(5)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_no(irq_n));

  always @(posedge clk) rd_q <= rd_en;

  // monitor: compare read data against scoreboard
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: got %h exp %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", t, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = 5'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [7:0] e, input string t);
    @(negedge clk); addr = 5'(a); rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        idle(2); rst_n = 1; idle(2);
        // R4 reset state
        chk(irq_n, 2'b11, "R4 irq after reset");
        rd(8, 8'hFF, "R4 mask0 b0"); rd(10, 8'hFF, "R4 mask0 b2");
        rd(12, 8'hFF, "R4 mask1 b0"); rd(0, 8'h00, "R4 stat0 b0");
        rd(16, 8'h00, "R4 edge b0"); rd(24, 8'h00, "R4 ctrl");
        // unmask line0 fully
        wr(8, 8'h00); wr(9, 8'h00); wr(10, 8'h00);
        // R3 no edge config
        src[0] = 1; idle(6);
        rd(0, 8'h00, "R3 unconfigured source");
        src[0] = 0; idle(6);
        // R2 config: src0 rising, src5 falling, src13 both
        wr(16, 8'h02); wr(17, 8'h04); wr(19, 8'h0C);
        rd(19, 8'h0C, "R2 edge byte readback");
        @(negedge clk); src[0] = 1;
        idle(3); chk(irq_n[0], 1'b1, "R10 irq not before status");
        idle(1); chk(irq_n[0], 1'b0, "R10 irq low");
        chk(irq_n[1], 1'b1, "R1 line1 masked");
        rd(0, 8'h01, "R2 rising src0");
        rd(4, 8'h00, "R1 line1 status clear");
        wr(0, 8'h01); idle(2);
        rd(0, 8'h00, "R6 write-1 clear");
        chk(irq_n[0], 1'b1, "R10 irq released");
        src[0] = 0; idle(6);
        rd(0, 8'h00, "R2 falling not enabled src0");
        // src5 falling only
        src[5] = 1; idle(6);
        rd(0, 8'h00, "R2 src5 rise ignored");
        src[5] = 0; idle(6);
        rd(0, 8'h20, "R2 src5 falling");
        wr(0, 8'h20);
        // R1/R9 line1 unmask byte1
        wr(13, 8'h00);
        src[13] = 1; idle(6);
        rd(1, 8'h20, "R9 stat0 byte1 src13");
        rd(5, 8'h20, "R1 stat1 byte1 src13");
        src[13] = 0; idle(6);
        // R7 held-over with write clear
        wr(1, 8'h20); rd(1, 8'h20, "R7 refilled after first clear");
        wr(1, 8'h20); rd(1, 8'h00, "R7 second clear");
        // R5 clear-on-read, line1 had a held-over event
        wr(24, 8'h01);
        rd(5, 8'h20, "R5 cor read 1");
        rd(5, 8'h20, "R7 cor refill");
        rd(5, 8'h00, "R5 cor empty");
        // R6 write ignored in cor mode
        src[0] = 1; idle(6);
        wr(0, 8'hFF);
        rd(0, 8'h01, "R6 write ignored under cor");
        rd(0, 8'h00, "R5 cleared by read");
        src[0] = 0; idle(6);
        // R8 drop repeats
        wr(24, 8'h03);
        src[13] = 1; idle(6); src[13] = 0; idle(6);
        rd(1, 8'h20, "R8 first read");
        rd(1, 8'h00, "R8 repeat dropped");
        rd(5, 8'h20, "R8 line1 first read");
        rd(5, 8'h00, "R8 line1 repeat dropped");
        // R11 event meets clear
        src[0] = 1; idle(6); src[0] = 0; idle(6);
        @(negedge clk); src[0] = 1;
        @(negedge clk);
        rd(0, 8'h01, "R11 read at event cycle");
        rd(0, 8'h01, "R11 bit kept");
        rd(0, 8'h00, "R11 then cleared");
        idle(2);
        chk(irq_n, 2'b11, "R10 both lines idle");
      end
      begin
        idle(20000);
        bad++; total++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule